// File: doc/BRIEF.md
# Per-Word Interrupt Control FIFO

This block lets writes to chosen words of a replicated memory raise interrupts between nodes. Each word offset has a local, unshared control entry with two enables: one marks the word as a source of outgoing interrupt messages, the other marks it as a word whose incoming interrupt messages the local host wants to hear about. A local write to a source word produces an outgoing message carrying the word offset. An incoming message for a listened-to word places that offset in a small queue that the host service routine reads.

Interrupts are coalesced. The first offset queued while the line is low raises the host line and holds it high. Offsets that arrive while it is high are only queued. The host drains the queue until it reads empty and then pulses a re-arm input. If offsets are still waiting at that point, the line stays high, so no event is lost between the last read and the re-arm.

Top module: `word_irq_ctrl`

## Requirements
- R1: After reset the host line `irq` is 0, `pop_empty` is 1, `tx_valid` is 0, `ovf` is 0 and every control entry reads 0.
- R2: A write on the configuration port with `cfg_we` stores `cfg_wdata` (bit 1 = send enable, bit 0 = receive enable) for word `cfg_addr`. `cfg_rdata` shows the entry at `cfg_addr` in the same cycle. Received messages never change any entry.
- R3: A snooped local write (`snp_we`) to a word whose send enable is set gives `tx_valid`=1 with `tx_addr` equal to the offset on the next cycle. A write to a word without the send enable gives no message. A configuration write in the same cycle as the snoop takes effect only for later snoops.
- R4: A received message (`rx_valid`) for a word whose receive enable is set is queued. A message for any other word is discarded. Offsets leave the queue in arrival order.
- R5: When an offset is queued while `irq` is 0, `irq` becomes 1 on the next cycle.
- R6: While `irq` is 1, further queued offsets and host reads leave it at 1 until a re-arm.
- R7: The queue holds 16 offsets. An accepted message arriving while 16 are held is dropped, even if a read occurs in the same cycle, and it sets `ovf`. `ovf` stays set until reset.
- R8: A cycle with `irq_rearm` high makes `irq` 0 on the next cycle if the queue will be empty then. Otherwise `irq` stays 1.
- R9: `pop_data` shows the oldest queued offset whenever `pop_empty` is 0. `pop_req` removes it on the clock edge. `pop_req` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control entry write strobe |
| cfg_addr | input | ADDR_W | Word offset for entry write and read |
| cfg_wdata | input | 2 | New entry: bit 1 send enable, bit 0 receive enable |
| cfg_rdata | output | 2 | Entry currently stored at cfg_addr |
| snp_we | input | 1 | Local write seen on the memory port |
| snp_addr | input | ADDR_W | Offset of the local write |
| tx_valid | output | 1 | Outgoing interrupt message valid |
| tx_addr | output | ADDR_W | Offset carried by the outgoing message |
| rx_valid | input | 1 | Incoming interrupt message valid |
| rx_addr | input | ADDR_W | Offset carried by the incoming message |
| pop_req | input | 1 | Remove the head offset |
| pop_data | output | ADDR_W | Head offset |
| pop_empty | output | 1 | Queue holds no offsets |
| irq_rearm | input | 1 | Host re-enables the interrupt |
| irq | output | 1 | Host interrupt line |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The checker watches, on every cycle, the properties that depend only on the ports: a rising `irq` always comes with a non-empty queue, `irq` holds until a re-arm, the level after a re-arm matches queue occupancy, `ovf` never clears, and each message has a snooped write behind it. Some behaviour can only be shown by the bench's scenarios. These are the filtering of messages by the per-word enables, the first-in first-out order of offsets, the old-entry rule when a configuration write and a snoop share a cycle, and which arrival is dropped at 16 entries.

// File: rtl/word_irq_ctrl.sv
module word_irq_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] tx_addr,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] pop_data,
  output logic              pop_empty,
  input  logic              irq_rearm,
  output logic              irq,
  output logic              ovf
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [WORDS-1:0]  send_en, recv_en;
  logic [ADDR_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              full, push_req, push_ok, pop_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_en <= '0;
      recv_en <= '0;
    end else if (cfg_we) begin
      send_en[cfg_addr] <= cfg_wdata[1];
      recv_en[cfg_addr] <= cfg_wdata[0];
    end
  end

  assign cfg_rdata = {send_en[cfg_addr], recv_en[cfg_addr]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_addr  <= '0;
    end else begin
      tx_valid <= snp_we & send_en[snp_addr];
      tx_addr  <= snp_addr;
    end
  end

  assign full     = (cnt == FULL_CNT);
  assign push_req = rx_valid & recv_en[rx_addr];
  assign push_ok  = push_req & ~full;
  assign pop_ok   = pop_req & (cnt != '0);

  always_comb begin
    cnt_n = cnt;
    if (push_ok && !pop_ok) cnt_n = cnt + 1'b1;
    if (pop_ok && !push_ok) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= rx_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt_n;
      ovf <= ovf | (push_req & full);
      irq <= irq_rearm ? (cnt_n != '0) : (irq | push_ok);
    end
  end

  assign pop_data  = mem[rd_ptr];
  assign pop_empty = (cnt == '0);
endmodule

module word_irq_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_we,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              tx_valid,
  input logic [ADDR_W-1:0] tx_addr,
  input logic              irq_rearm,
  input logic              irq,
  input logic              pop_empty,
  input logic              ovf
);
  p_tx_from_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(snp_we) && tx_addr == $past(snp_addr)));
  p_rise_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !pop_empty);
  p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_rearm) |=> irq);
  p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_rearm_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rearm |=> (irq == !pop_empty));
endmodule

bind word_irq_ctrl word_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_we(snp_we), .snp_addr(snp_addr),
  .tx_valid(tx_valid), .tx_addr(tx_addr), .irq_rearm(irq_rearm),
  .irq(irq), .pop_empty(pop_empty), .ovf(ovf)
);

// File: tb/test_word_irq_ctrl.sv
module test_word_irq_ctrl;
  localparam int AW = 8;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, snp_we = 0, rx_valid = 0, pop_req = 0, irq_rearm = 0;
  logic [AW-1:0] cfg_addr = '0, snp_addr = '0, rx_addr = '0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_rdata;
  logic tx_valid, pop_empty, irq, ovf;
  logic [AW-1:0] tx_addr, pop_data;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_q[$];
  bit model_recv [1 << AW];
  int model_cnt = 0;

  always #10 clk = ~clk;

  word_irq_ctrl #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) i_word_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .snp_we(snp_we),
    .snp_addr(snp_addr), .tx_valid(tx_valid), .tx_addr(tx_addr),
    .rx_valid(rx_valid), .rx_addr(rx_addr), .pop_req(pop_req),
    .pop_data(pop_data), .pop_empty(pop_empty), .irq_rearm(irq_rearm),
    .irq(irq), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model_recv[a] = d[0];
  endtask

  task automatic rd_cfg(input int a, input logic [1:0] exp, input string req);
    cfg_addr = AW'(a);
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic snoop(input int a, input bit exp_tx, input string req);
    @(negedge clk);
    snp_we = 1; snp_addr = AW'(a);
    @(negedge clk);
    snp_we = 0;
    chk(tx_valid == exp_tx, req, tx_valid, exp_tx);
    if (exp_tx) chk(tx_addr == AW'(a), req, tx_addr, a);
  endtask

  // driver: posts the expected offset to the scoreboard when it is accepted
  task automatic rx(input int a);
    @(negedge clk);
    rx_valid = 1; rx_addr = AW'(a);
    if (model_recv[a] && model_cnt < DEPTH) begin
      exp_q.push_back(AW'(a));
      model_cnt++;
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  // monitor: compares the head against the scoreboard and removes it
  task automatic pop_check(input string req);
    logic [AW-1:0] e;
    @(negedge clk);
    if (exp_q.size() == 0) begin
      chk(pop_empty == 1, req, pop_empty, 1);
    end else begin
      e = exp_q.pop_front();
      model_cnt--;
      chk(pop_empty == 0, req, pop_empty, 0);
      chk(pop_data == e, req, pop_data, e);
    end
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
  endtask

  task automatic rearm(input bit exp_irq, input string req);
    @(negedge clk);
    irq_rearm = 1;
    @(negedge clk);
    irq_rearm = 0;
    chk(irq == exp_irq, req, irq, exp_irq);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(irq == 0, "R1 irq", irq, 0);
    chk(pop_empty == 1, "R1 empty", pop_empty, 1);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk(ovf == 0, "R1 ovf", ovf, 0);
    rd_cfg(77, 2'b00, "R1 entry");

    // R2
    cfg(5, 2'b11); cfg(9, 2'b01); cfg(12, 2'b10);
    rd_cfg(5, 2'b11, "R2 word5");
    rd_cfg(9, 2'b01, "R2 word9");
    rd_cfg(12, 2'b10, "R2 word12");

    // R3
    snoop(12, 1, "R3 send enabled");
    snoop(9, 0, "R3 send disabled");
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(20); cfg_wdata = 2'b10;
    snp_we = 1; snp_addr = AW'(20);
    @(negedge clk);
    cfg_we = 0; snp_we = 0;
    chk(tx_valid == 0, "R3 same-cycle cfg uses old entry", tx_valid, 0);
    snoop(20, 1, "R3 later snoop sees new entry");

    // R4 / R5 / R6
    rx(12);
    chk(pop_empty == 1, "R4 receive disabled dropped", pop_empty, 1);
    chk(irq == 0, "R4 no irq for dropped", irq, 0);
    rx(9);
    chk(irq == 1, "R5 first entry raises irq", irq, 1);
    rx(5);
    chk(irq == 1, "R6 stays high", irq, 1);
    rd_cfg(9, 2'b01, "R2 entry unchanged by rx");
    rd_cfg(12, 2'b10, "R2 entry unchanged by rx");
    pop_check("R4 order first");
    pop_check("R4 order second");
    chk(irq == 1, "R6 high after drain", irq, 1);
    pop_check("R9 pop on empty");
    chk(pop_empty == 1, "R9 empty stays", pop_empty, 1);

    // R8
    rearm(0, "R8 rearm with empty queue");
    rx(5); rx(9); rx(5);
    chk(irq == 1, "R5 raised again", irq, 1);
    rearm(1, "R8 rearm with pending entries");
    pop_check("R9 head a");
    pop_check("R9 head b");
    pop_check("R9 head c");
    rearm(0, "R8 rearm after drain");

    // R7
    for (int i = 0; i < DEPTH; i++) rx((i % 2) ? 5 : 9);
    chk(ovf == 0, "R7 no overflow at 16", ovf, 0);
    @(negedge clk);
    rx_valid = 1; rx_addr = AW'(5); pop_req = 1;
    exp_q.pop_front(); model_cnt--;
    @(negedge clk);
    rx_valid = 0; pop_req = 0;
    chk(ovf == 1, "R7 overflow on push at full", ovf, 1);
    for (int i = 0; i < DEPTH - 1; i++) pop_check("R7 stored entries");
    chk(pop_empty == 1, "R7 dropped entry absent", pop_empty, 1);
    rearm(0, "R8 rearm final");
    chk(ovf == 1, "R7 ovf sticky", ovf, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule